// File: doc/BRIEF.md
# Received Signal Strength Averager

This block turns a stream of per-symbol received-power samples, already expressed in decibels as signed two's complement numbers, into one signed 8-bit strength figure with 1 dB per step. It keeps the last eight samples taken while the receiver is on. Each symbol strobe drops the oldest sample and adds the newest, and the strength register is loaded with the floor of the window sum divided by eight, clamped to the signed byte range.

A valid flag marks the register as trustworthy. It is set only once the receiver has been on for a full window of eight symbols. Turning the receiver off empties the window, zeroes the register and clears the flag, so the next reading again waits for eight fresh symbols. The frame logic can ask for a byte to append to a received frame. One cycle after the request the block returns the current strength, or the most negative code when no valid reading exists.

Top module: `sig_strength_avg`

## Requirements
- R1: After reset, `strength` is 0, `strength_vld` is 0 and `app_vld` is 0.
- R2: With `rx_en` held high, `strength_vld` stays 0 through the first seven accepted strobes. It becomes 1 on the clock edge that accepts the eighth strobe and stays 1 while `rx_en` stays high.
- R3: A strobe is accepted on a rising clock edge where `rx_en` and `sym_stb` are both 1. Once the window is full, every accepted strobe loads `strength` in that same edge with floor(S/8), where S is the sum of the last eight accepted `pwr_smp` values, each read as a signed two's complement number. `strength` is a two's complement byte with 1 dB per LSB.
- R4: An average above +127 loads 127 (0x7F), and an average below -128 loads -128 (0x80).
- R5: While `rx_en` is 0, strobes are ignored, `strength_vld` and `strength` read 0 one edge later, and the window history and symbol count are cleared. After re-enabling, seven strobes again leave `strength_vld` at 0.
- R6: `strength` does not change on an edge that accepts no strobe while `rx_en` is 1.
- R7: `append_req` sampled at an edge gives `app_vld` = 1 for the following cycle, and `app_vld` is 0 otherwise. `app_byte` is the `strength` value present before that edge when `strength_vld` was 1, and 0x80 when it was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiver enabled; low clears the averager |
| sym_stb | input | 1 | One-cycle pulse per symbol period |
| pwr_smp | input | SAMPLE_W | Signed per-symbol power sample in dB |
| strength | output | 8 | Signed averaged strength, 1 dB steps |
| strength_vld | output | 1 | Receiver has been on for a full window |
| append_req | input | 1 | Request for the frame-append byte |
| app_byte | output | 8 | Strength byte for the frame, 0x80 when not valid |
| app_vld | output | 1 | `app_byte` is valid this cycle |

## Verification
On every cycle the assertions check the control timing. The flag drops after the receiver is disabled, the flag only rises on an edge that takes a strobe, the register holds between strobes, and the append handshake holds its one-cycle latency and its fallback byte. The arithmetic can only be shown by the bench's scenarios: the eight-sample floor average, the clamping at both ends of the byte range, the exact strobe count that sets the flag, and the emptying of the history after a disable. The bench checks these against a sliding-window model it keeps itself, using an exhaustive sweep of constant inputs and long random streams.

// File: rtl/sigavg_pkg.sv
package sigavg_pkg;
  localparam int OUT_W = 8;

  // Clamp a signed value to the signed byte range.
  function automatic logic [OUT_W-1:0] clamp_byte(input logic signed [31:0] v);
    if (v > 32'sd127)       return 8'h7F;
    else if (v < -32'sd128) return 8'h80;
    else                    return v[OUT_W-1:0];
  endfunction
endpackage

// File: rtl/sigavg_window.sv
module sigavg_window #(
  parameter int SAMPLE_W = 10,
  parameter int WIN_LOG2 = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         shift,
  input  logic [SAMPLE_W-1:0]          sample,
  output logic [SAMPLE_W+WIN_LOG2-1:0] sum_nxt
);
  localparam int WIN   = 1 << WIN_LOG2;
  localparam int SUM_W = SAMPLE_W + WIN_LOG2;

  logic [SAMPLE_W-1:0] hist_q [WIN];
  logic [SAMPLE_W-1:0] hist_d [WIN];
  logic [SUM_W-1:0]    sum_q;
  logic [SUM_W-1:0]    new_ext;
  logic [SUM_W-1:0]    old_ext;
  logic                hist_en;

  assign hist_en = clr | shift;
  assign new_ext = {{WIN_LOG2{sample[SAMPLE_W-1]}}, sample};
  assign old_ext = {{WIN_LOG2{hist_q[WIN-1][SAMPLE_W-1]}}, hist_q[WIN-1]};

  always_comb begin
    if (clr)        sum_nxt = '0;
    else if (shift) sum_nxt = sum_q + new_ext - old_ext;
    else            sum_nxt = sum_q;
  end

  for (genvar i = 0; i < WIN; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign hist_d[i] = clr ? '0 : sample;
    end else begin : g_body
      assign hist_d[i] = clr ? '0 : hist_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist_q[i] <= '0;
      else if (hist_en) hist_q[i] <= hist_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_nxt;
  end
endmodule

// File: rtl/sigavg_fill.sv
module sigavg_fill #(
  parameter int WIN_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift,
  output logic full_nxt,
  output logic full_q
);
  localparam int WIN   = 1 << WIN_LOG2;
  localparam int CNT_W = WIN_LOG2 + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)                                  cnt_d = '0;
    else if (shift && cnt_q != CNT_W'(WIN))   cnt_d = cnt_q + 1'b1;
    full_nxt = (cnt_d == CNT_W'(WIN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_nxt;
    end
  end
endmodule

// File: rtl/sig_strength_avg.sv
module sig_strength_avg
  import sigavg_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int WIN_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                sym_stb,
  input  logic [SAMPLE_W-1:0] pwr_smp,
  output logic [7:0]          strength,
  output logic                strength_vld,
  input  logic                append_req,
  output logic [7:0]          app_byte,
  output logic                app_vld
);
  localparam int SUM_W = SAMPLE_W + WIN_LOG2;

  logic             rst_meta_n, rst_sync_n;
  logic             clr, shift, full_nxt;
  logic [SUM_W-1:0] sum_nxt;
  logic [SUM_W-1:0] avg;
  logic [7:0]       str_d, app_d;
  logic             str_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign clr   = ~rx_en;
  assign shift = rx_en & sym_stb;

  sigavg_window #(.SAMPLE_W(SAMPLE_W), .WIN_LOG2(WIN_LOG2)) u_window (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .shift(shift),
    .sample(pwr_smp), .sum_nxt(sum_nxt)
  );

  sigavg_fill #(.WIN_LOG2(WIN_LOG2)) u_fill (
    .clk(clk), .rst_n(rst_sync_n), .clr(clr), .shift(shift),
    .full_nxt(full_nxt), .full_q(strength_vld)
  );

  assign avg = $signed(sum_nxt) >>> WIN_LOG2;

  always_comb begin
    str_en = clr | (shift & full_nxt);
    str_d  = clr ? 8'h00 : clamp_byte(32'(signed'(avg)));
    app_d  = strength_vld ? strength : 8'h80;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  strength <= 8'h00;
    else if (str_en)  strength <= str_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      app_vld  <= 1'b0;
      app_byte <= 8'h00;
    end else begin
      app_vld <= append_req;
      if (append_req) app_byte <= app_d;
    end
  end
endmodule

// File: rtl/sig_strength_avg_chk.sv
module sig_strength_avg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       sym_stb,
  input logic [7:0] strength,
  input logic       strength_vld,
  input logic       append_req,
  input logic [7:0] app_byte,
  input logic       app_vld
);
  assert_vld_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !strength_vld);

  assert_str_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> strength == 8'h00);

  assert_vld_rise_on_stb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strength_vld) |-> $past(sym_stb) && $past(rx_en));

  assert_hold_between_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en) && !$past(sym_stb) |-> $stable(strength));

  assert_app_follows_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    append_req |=> app_vld);

  assert_app_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !append_req |=> !app_vld);

  assert_app_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    append_req && !strength_vld |=> app_byte == 8'h80);
endmodule

bind sig_strength_avg sig_strength_avg_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .rx_en(rx_en), .sym_stb(sym_stb),
  .strength(strength), .strength_vld(strength_vld),
  .append_req(append_req), .app_byte(app_byte), .app_vld(app_vld)
);

// File: tb/tb_sig_strength_avg.sv
module tb_sig_strength_avg;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_en = 1'b0;
  logic          sym_stb = 1'b0;
  logic [SW-1:0] pwr_smp = '0;
  logic          append_req = 1'b0;
  logic [7:0]    strength, app_byte;
  logic          strength_vld, app_vld;

  int n_cmp = 0;
  int n_bad = 0;
  int hist [8];
  int cnt = 0;
  int exp_str = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_strength_avg dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .sym_stb(sym_stb),
    .pwr_smp(pwr_smp), .strength(strength), .strength_vld(strength_vld),
    .append_req(append_req), .app_byte(app_byte), .app_vld(app_vld)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int clamp(input int v);
    if (v > 127)  return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int sbyte(input logic [7:0] b);
    return int'($signed(b));
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) hist[i] = 0;
    cnt = 0;
    exp_str = 0;
  endtask

  task automatic set_en(input logic en);
    rx_en = en;
    tick();
    if (!en) begin
      model_clear();
      check("R5 vld", strength_vld, 0);
      check("R5 str", sbyte(strength), 0);
    end
  endtask

  // One strobe with sample s, then gap idle cycles checking the hold (R6).
  task automatic strobe(input int s, input int gap);
    int sum;
    sym_stb = 1'b1;
    pwr_smp = SW'(s);
    tick();
    sym_stb = 1'b0;
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    if (cnt < 8) cnt++;
    sum = 0;
    for (int i = 0; i < 8; i++) sum += hist[i];
    if (cnt == 8) exp_str = clamp(sum >>> 3);
    check("R2 vld", strength_vld, (cnt == 8) ? 1 : 0);
    check((sum > 1023 || sum < -1024) ? "R4 sat" : "R3 avg", sbyte(strength), exp_str);
    for (int g = 0; g < gap; g++) begin
      tick();
      check("R6 hold", sbyte(strength), exp_str);
    end
  endtask

  task automatic do_append();
    int exp_b;
    exp_b = (cnt == 8) ? exp_str : -128;
    append_req = 1'b1;
    tick();
    append_req = 1'b0;
    check("R7 app_vld", app_vld, 1);
    check("R7 app_byte", sbyte(app_byte), exp_b);
    tick();
    check("R7 app_vld low", app_vld, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 str", sbyte(strength), 0);
    check("R1 vld", strength_vld, 0);
    check("R1 app_vld", app_vld, 0);

    // Fill count and append fallback.
    set_en(1'b1);
    do_append();
    for (int k = 0; k < 8; k++) strobe(k * 3 - 10, k % 3);
    do_append();

    // R5: strobes while disabled are ignored, history emptied.
    rx_en = 1'b0;
    sym_stb = 1'b1;
    pwr_smp = SW'(500);
    repeat (3) tick();
    sym_stb = 1'b0;
    model_clear();
    check("R5 vld off", strength_vld, 0);
    check("R5 str off", sbyte(strength), 0);
    set_en(1'b1);
    for (int k = 0; k < 7; k++) strobe(100, 0);
    check("R5 refill vld", strength_vld, 0);
    strobe(-4, 1);

    // Exhaustive sweep of constant inputs over the whole sample range.
    for (int v = -512; v < 512; v++) begin
      set_en(1'b0);
      set_en(1'b1);
      for (int k = 0; k < 8; k++) strobe(v, 0);
    end

    // Random streams: full range and near the clamp thresholds.
    set_en(1'b0);
    set_en(1'b1);
    for (int k = 0; k < 3000; k++) begin
      strobe($urandom_range(0, 1023) - 512, $urandom_range(0, 2));
      if (k % 97 == 0) do_append();
    end
    for (int k = 0; k < 3000; k++) begin
      strobe($urandom_range(0, 300) - 150, $urandom_range(0, 1));
      if (k % 89 == 0) do_append();
      if (k % 701 == 0) set_en(1'b0);
      if (k % 701 == 0) set_en(1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule